// File: doc/BRIEF.md
# Dual-Width Flash Bus Front End

This block is the device-side front end of a parallel NOR-style flash part. Asynchronous bus strobes (chip select, write strobe, output strobe, address latch strobe and a power-down/reset pin) are passed through two-flop synchronizers into the system clock domain. Rising edges are detected there, and the block decides which edge captures the address and which captures write data.

Read data goes out on a 32-bit bidirectional bus. In full-width mode the whole stored double-word appears on all 32 lines. In half-width mode one half-word appears on the low 16 lines, selected by the lowest address bit (A1), and the upper lines float. A small read-mode register selects the data source: array contents, identifier codes or the status byte. While the stub program engine is busy, only one ready/busy line is driven.

A small double-word array stub and a fixed-length busy counter stand in for the storage and for the program algorithm.

Top module: `flash_bus_front`

## Requirements
- R1: The address is captured on the first rising edge of chip select, write strobe or latch strobe in a write cycle (or by a latch-strobe rise alone). Later rising edges before the write cycle ends (both chip select and write strobe high) do not replace it. After the capture the address holds while the latch strobe stays high.
- R2: While the latch strobe is low and no capture is held, the internal address follows the `addr` pins.
- R3: Write data is captured on the first rising edge of write strobe or chip select in a cycle where both were low together. Data that changes after that edge is not used.
- R4: In full-width mode (`word_mode`=1) the address bit `addr[0]` (A1) is ignored, and the stored double-word drives `dq[31:0]` with its low half on `dq[15:0]`.
- R5: In half-width mode (`word_mode`=0), `addr[0]`=0 puts bits 15:0 of the double-word on `dq[15:0]` and `addr[0]`=1 puts bits 31:16 there. `dq[31:16]` float.
- R6: `dq` is driven only when the synchronized chip select and output strobe are both low and the power-down pin is high. Otherwise every line floats.
- R7: A program runs for `BUSY_CYC` clock cycles. During that time a read drives only `dq[7]`, at 0 (busy), and floats all other lines. When the count ends, the array is updated.
- R8: In identifier mode, double-word index 0 reads 0020h and index 1 reads 8819h in the low half. The upper half and every other index read 0.
- R9: Command bytes on `dq[7:0]` select the read source: FFh selects array, 90h selects identifier and 70h selects status. 40h arms a program, and the next written data and address program the array. The status read returns bit 7 = 1 when the engine is idle, with all other bits 0.
- R10: While the power-down pin is low, the address latch is cleared to 0, the read mode returns to array, and a running program is abandoned without changing the array.
- R11: A program in half-width mode writes only the half-word selected by `addr[0]` and leaves the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | System reset, active low; loads the array stub pattern |
| ce_n | input | 1 | Chip select strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| le_n | input | 1 | Address latch strobe; latch transparent while low |
| rp_n | input | 1 | Power-down/reset pin, active low |
| word_mode | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| addr | input | AW | Address, bit 0 is A1 (half-word select), upper bits pick the double-word |
| dq | inout | 32 | Bidirectional data bus |

## Verification
The bound checker checks every cycle that the bus floats outside an enabled read, that only the ready/busy line drives during a program, that the upper lanes stay quiet in half-width mode, that all lanes drive in an idle full-width read, that the busy count stays in range, and that power-down abandons the program and resets the mode. Some properties depend on edge ordering or on data history, and only the bench scenarios can show them. These are: which strobe wins the address capture, that late data is ignored, that the identifier and status values are correct, that array contents survive an aborted program, and that a half-width program changes only one half.

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
  parameter int AW = 5,
  parameter int BUSY_CYC = 40,
  parameter logic [15:0] MFR_CODE = 16'h0020,
  parameter logic [15:0] DEV_CODE = 16'h8819
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          le_n,
  input  logic          rp_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  inout  wire  [31:0]   dq
);
  localparam int IW = AW - 1;
  localparam int DEPTH = 1 << IW;
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [1:0] MD_ARR = 2'd0, MD_ID = 2'd1, MD_ST = 2'd2;

  logic [4:0] s1, s2;
  logic [2:0] prv;
  logic ce_s, we_s, oe_s, le_s, rp_s;
  assign {rp_s, le_s, oe_s, we_s, ce_s} = s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 5'h1F; s2 <= 5'h1F; prv <= 3'h7;
    end else begin
      s1 <= {rp_n, le_n, oe_n, we_n, ce_n};
      s2 <= s1;
      prv <= {le_s, we_s, ce_s};
    end

  wire rise_ce = ce_s & ~prv[0];
  wire rise_we = we_s & ~prv[1];
  wire rise_le = le_s & ~prv[2];
  wire fall_le = ~le_s & prv[2];

  logic          aheld, dheld, wr_seen, busy, arm;
  logic [AW-1:0] addr_lat, addr_nxt;
  logic [1:0]    mode;
  logic [CW-1:0] cnt;
  logic [IW-1:0] pidx;
  logic [31:0]   pdata, pmask;
  logic [31:0]   arr [DEPTH];

  wire [31:0] dq_in = dq;
  wire a_cap  = !aheld && (rise_le || (wr_seen && (rise_ce || rise_we)));
  wire d_cap  = wr_seen && !dheld && (rise_ce || rise_we);
  wire wr_end = wr_seen && ce_s && we_s;

  always_comb begin
    addr_nxt = addr_lat;
    if (!aheld && (a_cap || !le_s)) addr_nxt = addr;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_lat <= '0; aheld <= 1'b0; dheld <= 1'b0; wr_seen <= 1'b0;
      busy <= 1'b0; arm <= 1'b0; cnt <= '0; mode <= MD_ARR;
      pidx <= '0; pdata <= '0; pmask <= '0;
      for (int i = 0; i < DEPTH; i++)
        arr[i] <= {16'h5A00 + 16'(i), 16'h0F00 + 16'(i)};
    end else if (!rp_s) begin
      addr_lat <= '0; aheld <= 1'b0; dheld <= 1'b0; wr_seen <= 1'b0;
      busy <= 1'b0; arm <= 1'b0; cnt <= '0; mode <= MD_ARR;
    end else begin
      addr_lat <= addr_nxt;
      if (wr_end || fall_le) aheld <= 1'b0;
      else if (a_cap) aheld <= 1'b1;
      if (wr_end) wr_seen <= 1'b0;
      else if (!ce_s && !we_s) wr_seen <= 1'b1;
      if (wr_end) dheld <= 1'b0;
      else if (d_cap) dheld <= 1'b1;

      if (busy) begin
        if (cnt == CW'(BUSY_CYC - 1)) begin
          busy <= 1'b0;
          cnt <= '0;
          arr[pidx] <= (arr[pidx] & ~pmask) | (pdata & pmask);
        end else cnt <= cnt + 1'b1;
      end else if (d_cap) begin
        if (arm) begin
          arm <= 1'b0;
          busy <= 1'b1;
          cnt <= '0;
          pidx <= addr_nxt[AW-1:1];
          if (word_mode) begin
            pdata <= dq_in;
            pmask <= '1;
          end else begin
            pdata <= {dq_in[15:0], dq_in[15:0]};
            pmask <= addr_nxt[0] ? 32'hFFFF_0000 : 32'h0000_FFFF;
          end
        end else begin
          case (dq_in[7:0])
            8'hFF: mode <= MD_ARR;
            8'h90: mode <= MD_ID;
            8'h70: mode <= MD_ST;
            8'h40: arm <= 1'b1;
            default: ;
          endcase
        end
      end
    end

  wire [IW-1:0] idx = addr_lat[AW-1:1];
  wire          a1  = addr_lat[0];
  logic [31:0]  src;
  always_comb
    case (mode)
      MD_ID:   src = (idx == 0) ? {16'h0, MFR_CODE} : (idx == 1) ? {16'h0, DEV_CODE} : 32'h0;
      MD_ST:   src = {24'h0, ~busy, 7'h0};
      default: src = arr[idx];
    endcase

  wire out_ok = rp_s && !ce_s && !oe_s;
  logic [31:0] drv_val, drv_en;
  always_comb begin
    drv_val = '0;
    drv_en  = '0;
    if (out_ok) begin
      if (busy) begin
        drv_en[7] = 1'b1;
      end else if (word_mode) begin
        drv_val = src;
        drv_en  = '1;
      end else begin
        drv_val[15:0] = a1 ? src[31:16] : src[15:0];
        drv_en[15:0]  = '1;
      end
    end
  end

  for (genvar i = 0; i < 32; i++) begin : g_dq
    assign dq[i] = drv_en[i] ? drv_val[i] : 1'bz;
  end
endmodule

module flash_bus_front_chk #(
  parameter int BUSY_CYC = 40,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_s,
  input logic          oe_s,
  input logic          rp_s,
  input logic          word_mode,
  input logic          busy,
  input logic [1:0]    mode,
  input logic [CW-1:0] cnt,
  input logic [31:0]   drv_en
);
  // R6
  float_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rp_s && !ce_s && !oe_s) |-> drv_en == 32'h0);
  // R7
  busy_only_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rp_s && !ce_s && !oe_s) |-> drv_en == 32'h80);
  // R5
  upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> drv_en[31:16] == 16'h0);
  // R4
  full_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && word_mode && rp_s && !ce_s && !oe_s) |-> drv_en == 32'hFFFF_FFFF);
  // R10
  rp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_s |=> (!busy && mode == 2'd0));
  // R7
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CW'(BUSY_CYC));
endmodule

bind flash_bus_front flash_bus_front_chk #(.BUSY_CYC(BUSY_CYC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(s2[0]), .oe_s(s2[2]), .rp_s(s2[4]),
  .word_mode(word_mode), .busy(busy), .mode(mode), .cnt(cnt), .drv_en(drv_en)
);

// File: tb/flash_bus_front_tb.sv
`timescale 1ns/1ps
module flash_bus_front_tb;
  localparam int AW = 5;
  localparam int BUSY = 40;
  localparam int DEPTH = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, le_n = 1'b0, rp_n = 1'b1;
  logic word_mode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [31:0] tb_d = '0;
  logic tb_drv = 1'b0;
  wire  [31:0] dq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [DEPTH];
  logic [31:0] v;

  always #4 clk = ~clk;

  assign dq = tb_drv ? tb_d : 32'bz;
  for (genvar i = 0; i < 32; i++) begin : g_pu
    pullup pu_i (dq[i]);
  end

  flash_bus_front #(.AW(AW), .BUSY_CYC(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .le_n(le_n), .rp_n(rp_n), .word_mode(word_mode), .addr(addr), .dq(dq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] view(input logic [31:0] w, input logic wm, input logic a1);
    return wm ? w : {16'hFFFF, a1 ? w[31:16] : w[15:0]};
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; le_n = 1'b0; tb_d = d; tb_drv = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    ticks(4); we_n = 1'b1;
    ticks(4); ce_n = 1'b1;
    ticks(4); tb_drv = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] r);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    ticks(5); r = dq;
    oe_n = 1'b1; ce_n = 1'b1;
    ticks(3);
  endtask

  initial begin
    ticks(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {16'h5A00 + 16'(i), 16'h0F00 + 16'(i)};
    ticks(3); rst_n = 1'b1; ticks(3);

    // R6 reset state: deselected bus floats
    chk("R6 reset float", dq, 32'hFFFF_FFFF);

    // R2 R4 R5 sweep of every address in both widths, latch transparent
    for (int wm = 0; wm < 2; wm++) begin
      word_mode = wm[0];
      for (int a = 0; a < 2 * DEPTH; a++) begin
        rd(AW'(a), v);
        chk(wm ? "R4 full read" : "R5 half read", v, view(mem[a >> 1], wm[0], a[0]));
      end
    end

    // R6 partial enables
    word_mode = 1'b1;
    @(negedge clk); addr = 5'd2; ce_n = 1'b0; ticks(5);
    chk("R6 oe high", dq, 32'hFFFF_FFFF);
    ce_n = 1'b1; oe_n = 1'b0; ticks(5);
    chk("R6 ce high", dq, 32'hFFFF_FFFF);
    ce_n = 1'b0; rp_n = 1'b0; ticks(5);
    chk("R6 rp low", dq, 32'hFFFF_FFFF);
    rp_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; ticks(4);

    // R8 identifier codes
    wr(5'd0, 32'h90);
    for (int wm = 0; wm < 2; wm++) begin
      word_mode = wm[0];
      for (int a = 0; a < 6; a++) begin
        logic [31:0] e;
        e = (a >> 1) == 0 ? 32'h0020 : (a >> 1) == 1 ? 32'h8819 : 32'h0;
        rd(AW'(a), v);
        chk("R8 ident", v, view(e, wm[0], a[0]));
      end
    end

    // R9 status and return to array
    word_mode = 1'b1;
    wr(5'd0, 32'h70);
    rd(5'd3, v); chk("R9 status idle", v, 32'h0000_0080);
    word_mode = 1'b0;
    rd(5'd3, v); chk("R9 status half hi", v, 32'hFFFF_0000);
    word_mode = 1'b1;
    wr(5'd0, 32'hFF);
    rd(5'd6, v); chk("R9 back to array", v, mem[3]);

    // R7 R9 full-width program, busy window
    wr(5'd0, 32'h40);
    wr(5'd12, 32'h1234_0000);
    rd(5'd12, v); chk("R7 busy dq7 only", v, 32'hFFFF_FF7F);
    ticks(BUSY + 10);
    mem[6] = 32'h1234_0000;
    rd(5'd12, v); chk("R7 programmed", v, mem[6]);

    // R11 half-width program of upper half
    word_mode = 1'b0;
    wr(5'd0, 32'h40);
    wr(5'd7, 32'h0000_BEEF);
    ticks(BUSY + 10);
    mem[3][31:16] = 16'hBEEF;
    rd(5'd7, v); chk("R11 upper half written", v, {16'hFFFF, 16'hBEEF});
    rd(5'd6, v); chk("R11 lower half kept", v, {16'hFFFF, mem[3][15:0]});
    word_mode = 1'b1;

    // R3 data captured on first rise (chip select), later change ignored
    wr(5'd0, 32'h40);
    @(negedge clk);
    addr = 5'd10; le_n = 1'b0; tb_d = 32'h0A0B_0C0D; tb_drv = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    ticks(4); ce_n = 1'b1;
    ticks(4); tb_d = 32'h5555_5555;
    ticks(2); we_n = 1'b1;
    ticks(4); tb_drv = 1'b0;
    ticks(BUSY + 10);
    mem[5] = 32'h0A0B_0C0D;
    rd(5'd10, v); chk("R3 first edge data", v, mem[5]);

    // R10 power-down aborts program
    wr(5'd0, 32'h40);
    wr(5'd8, 32'hDEAD_BEEF);
    @(negedge clk); rp_n = 1'b0; ticks(6); rp_n = 1'b1; ticks(BUSY + 10);
    rd(5'd8, v); chk("R10 abort keeps array", v, mem[4]);
    // R10 mode reset and latch clear
    wr(5'd0, 32'h90);
    @(negedge clk); le_n = 1'b1; ticks(4);
    rp_n = 1'b0; ticks(6); rp_n = 1'b1; ticks(4);
    rd(5'd9, v); chk("R10 latch cleared, array mode", v, mem[0]);

    // R1 write strobe first; later latch/chip rises ignored
    @(negedge clk);
    addr = 5'd4; le_n = 1'b0; tb_d = 32'hFF; tb_drv = 1'b1;
    ticks(3); ce_n = 1'b0; we_n = 1'b0;
    ticks(4); we_n = 1'b1;
    ticks(4); addr = 5'd18;
    ticks(4); le_n = 1'b1;
    ticks(4); ce_n = 1'b1;
    ticks(4); tb_drv = 1'b0;
    rd(5'd18, v); chk("R1 write strobe first", v, mem[2]);

    // R1 latch strobe first
    @(negedge clk); addr = 5'd8; le_n = 1'b0;
    ticks(4); le_n = 1'b1;
    ticks(4); addr = 5'd22; tb_d = 32'hFF; tb_drv = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    ticks(4); we_n = 1'b1;
    ticks(4); ce_n = 1'b1;
    ticks(4); tb_drv = 1'b0;
    rd(5'd22, v); chk("R1 latch strobe first", v, mem[4]);

    // R2 transparency resumes when latch strobe falls
    @(negedge clk); le_n = 1'b0;
    rd(5'd22, v); chk("R2 transparent again", v, mem[11]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule